// File: doc/BRIEF.md
# Page-Class Bank Selector

This block sits between address translation and a banked last-level cache. It decides, for each request, which cache banks the request is allowed to search and which single bank holds the line. The choice depends on the class that translation attaches to the page. A private-data page stays in the bank next to the requesting core. A shared-instruction page is spread over the four-bank cluster that contains the requester's own bank. A shared-data page is interleaved over every bank by address.

The request also carries its access kind, either an instruction fetch or a data access. If the kind does not fit the page class, the request is blocked. A blocked request gets an empty bank mask and a raised violation flag.

Requests enter through a valid/ready handshake. Each accepted request produces one registered result, one cycle later, through a second valid/ready pair. The core count, bank count, cluster size, address width and block-offset width are parameters. By default there are 16 cores and 16 banks, with 64-byte blocks.

Top module: `page_bank_sel`

## Requirements
- R1: The class input is 2 bits: 2'b00 private data, 2'b01 shared instruction, 2'b10 shared data, 2'b11 reserved. The reserved code always raises the violation flag.
- R2: A data access (fetch input 0) to a private-data page returns the local bank, which is the core ID modulo the bank count. The mask has only that bank's bit set.
- R3: An instruction fetch (fetch input 1) to a shared-instruction page returns a bank whose upper bits are taken from the local bank and whose low 2 bits are address bits [7:6]. The mask has all 4 bits of that cluster set.
- R4: A data access to a shared-data page returns a bank equal to address bits [9:6]. The mask has every bit set.
- R5: Any fetch to a page that is not shared-instruction, and any data access to a shared-instruction or reserved page, raises the violation flag. The result then has a zero mask and bank 0.
- R6: A request accepted on a clock edge (request valid and ready both high) shows its result with the response valid flag high right after that edge.
- R7: While the response valid flag is high and the response ready input is low, the request ready output is low. The mask, bank and violation outputs stay unchanged.
- R8: After reset, the response valid flag is low, the mask is zero and the request ready output is high.
- R9: With the response ready input held high, a new request is accepted on every cycle. Each request's result appears on the cycle after it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_core_i | input | CORE_W (4) | Requesting core ID |
| req_addr_i | input | ADDR_W (48) | Physical address |
| req_class_i | input | 2 | Page class from translation |
| req_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| resp_valid_o | output | 1 | Result present |
| resp_ready_i | input | 1 | Result consumed |
| resp_mask_o | output | NUM_BANKS (16) | Banks to search |
| resp_bank_o | output | BANK_W (4) | Home bank of the line |
| resp_viol_o | output | 1 | Kind/class mismatch; request blocked |

## Verification
Every result is due exactly one clock edge after the edge that accepts its request. The bench drives inputs on the falling edge, lets one rising edge pass, and compares outputs on the next falling edge. A stalled result must stay in place over several rising edges while the next request waits. The bench checks it after each of those edges, and then checks the waiting request one edge after the stall is released.

// File: rtl/page_bank_sel_pkg.sv
package page_bank_sel_pkg;
  typedef enum logic [1:0] {
    PG_PRIV = 2'b00,
    PG_SH_I = 2'b01,
    PG_SH_D = 2'b10,
    PG_RSVD = 2'b11
  } pg_class_e;
endpackage

// File: rtl/page_bank_sel_map.sv
module page_bank_sel_map
  import page_bank_sel_pkg::*;
#(
  parameter int NUM_CORES     = 16,
  parameter int NUM_BANKS     = 16,
  parameter int CLUSTER_BANKS = 4,
  parameter int ADDR_W        = 48,
  parameter int BLK_OFF_W     = 6,
  localparam int CORE_W       = $clog2(NUM_CORES),
  localparam int BANK_W       = $clog2(NUM_BANKS),
  localparam int CL_W         = $clog2(CLUSTER_BANKS)
) (
  input  logic [CORE_W-1:0]    core_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           class_i,
  input  logic                 fetch_i,
  output logic [NUM_BANKS-1:0] mask_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic                 viol_o
);
  pg_class_e                cls;
  logic [BANK_W-1:0]        local_bank;
  logic [BANK_W-1:0]        si_bank;
  logic [BANK_W-1:0]        sd_bank;
  logic [NUM_BANKS-1:0]     raw_mask;

  assign cls        = pg_class_e'(class_i);
  assign local_bank = BANK_W'(32'(core_i) % NUM_BANKS);
  assign sd_bank    = addr_i[BLK_OFF_W +: BANK_W];

  generate
    if (CL_W < BANK_W) begin : g_cl_part
      assign si_bank = {local_bank[BANK_W-1:CL_W], addr_i[BLK_OFF_W +: CL_W]};
    end else begin : g_cl_full
      assign si_bank = addr_i[BLK_OFF_W +: BANK_W];
    end
  endgenerate

  // fetch may only target shared-instruction pages; data may not
  assign viol_o = fetch_i ? (cls != PG_SH_I)
                          : (cls == PG_SH_I || cls == PG_RSVD);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
    logic same_bank, same_cl;
    assign same_bank   = (BANK_W'(b) == local_bank);
    assign same_cl     = ((BANK_W'(b) >> CL_W) == (local_bank >> CL_W));
    assign raw_mask[b] = (cls == PG_SH_D)
                       | ((cls == PG_PRIV) & same_bank)
                       | ((cls == PG_SH_I) & same_cl);
  end

  always_comb begin
    mask_o = viol_o ? '0 : raw_mask;
    bank_o = '0;
    if (!viol_o) begin
      unique case (cls)
        PG_PRIV: bank_o = local_bank;
        PG_SH_I: bank_o = si_bank;
        PG_SH_D: bank_o = sd_bank;
        default: bank_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/page_bank_sel_stage.sv
module page_bank_sel_stage #(
  parameter int NUM_BANKS = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [NUM_BANKS-1:0] in_mask_i,
  input  logic [BANK_W-1:0]    in_bank_i,
  input  logic                 in_viol_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [NUM_BANKS-1:0] out_mask_o,
  output logic [BANK_W-1:0]    out_bank_o,
  output logic                 out_viol_o
);
  logic load;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign load       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_mask_o  <= '0;
      out_bank_o  <= '0;
      out_viol_o  <= 1'b0;
    end else begin
      if (load) begin
        out_valid_o <= 1'b1;
        out_mask_o  <= in_mask_i;
        out_bank_o  <= in_bank_i;
        out_viol_o  <= in_viol_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_bank_sel.sv
module page_bank_sel #(
  parameter int NUM_CORES     = 16,
  parameter int NUM_BANKS     = 16,
  parameter int CLUSTER_BANKS = 4,
  parameter int ADDR_W        = 48,
  parameter int BLK_OFF_W     = 6,
  localparam int CORE_W       = $clog2(NUM_CORES),
  localparam int BANK_W       = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [CORE_W-1:0]    req_core_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           req_class_i,
  input  logic                 req_fetch_i,
  output logic                 resp_valid_o,
  input  logic                 resp_ready_i,
  output logic [NUM_BANKS-1:0] resp_mask_o,
  output logic [BANK_W-1:0]    resp_bank_o,
  output logic                 resp_viol_o
);
  logic [NUM_BANKS-1:0] map_mask;
  logic [BANK_W-1:0]    map_bank;
  logic                 map_viol;

  page_bank_sel_map #(
    .NUM_CORES    (NUM_CORES),
    .NUM_BANKS    (NUM_BANKS),
    .CLUSTER_BANKS(CLUSTER_BANKS),
    .ADDR_W       (ADDR_W),
    .BLK_OFF_W    (BLK_OFF_W)
  ) u_map (
    .core_i (req_core_i),
    .addr_i (req_addr_i),
    .class_i(req_class_i),
    .fetch_i(req_fetch_i),
    .mask_o (map_mask),
    .bank_o (map_bank),
    .viol_o (map_viol)
  );

  page_bank_sel_stage #(
    .NUM_BANKS(NUM_BANKS)
  ) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (req_valid_i),
    .in_ready_o (req_ready_o),
    .in_mask_i  (map_mask),
    .in_bank_i  (map_bank),
    .in_viol_i  (map_viol),
    .out_valid_o(resp_valid_o),
    .out_ready_i(resp_ready_i),
    .out_mask_o (resp_mask_o),
    .out_bank_o (resp_bank_o),
    .out_viol_o (resp_viol_o)
  );
endmodule

// File: rtl/page_bank_sel_chk.sv
module page_bank_sel_chk #(
  parameter int NUM_BANKS     = 16,
  parameter int CLUSTER_BANKS = 4,
  parameter int BANK_W        = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic [1:0]           req_class_i,
  input logic                 req_fetch_i,
  input logic                 resp_valid_o,
  input logic                 resp_ready_i,
  input logic [NUM_BANKS-1:0] resp_mask_o,
  input logic [BANK_W-1:0]    resp_bank_o,
  input logic                 resp_viol_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  AST_RESERVED_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_class_i == 2'b11 |=> resp_viol_o) else $error("reserved"); // R1
  AST_PRIV_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_class_i == 2'b00 && !req_fetch_i |=> $countones(resp_mask_o) == 1 && resp_mask_o[resp_bank_o]) else $error("priv"); // R2
  AST_SHI_CLUSTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_class_i == 2'b01 && req_fetch_i |=> $countones(resp_mask_o) == CLUSTER_BANKS && resp_mask_o[resp_bank_o]) else $error("shi"); // R3
  AST_SHD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_class_i == 2'b10 && !req_fetch_i |=> resp_mask_o == '1) else $error("shd"); // R4
  AST_VIOL_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_viol_o |-> resp_mask_o == '0 && resp_bank_o == '0) else $error("viol"); // R5
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o) else $error("latency"); // R6
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i |=> resp_valid_o && $stable(resp_mask_o) && $stable(resp_bank_o) && $stable(resp_viol_o)) else $error("hold"); // R7
  AST_STALL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i |-> !req_ready_o) else $error("ready"); // R7
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> req_ready_o) else $error("idle"); // R8
endmodule

bind page_bank_sel page_bank_sel_chk #(
  .NUM_BANKS    (NUM_BANKS),
  .CLUSTER_BANKS(CLUSTER_BANKS),
  .BANK_W       (BANK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_class_i (req_class_i),
  .req_fetch_i (req_fetch_i),
  .resp_valid_o(resp_valid_o),
  .resp_ready_i(resp_ready_i),
  .resp_mask_o (resp_mask_o),
  .resp_bank_o (resp_bank_o),
  .resp_viol_o (resp_viol_o)
);

// File: tb/page_bank_sel_tb.sv
module page_bank_sel_tb;
  localparam int NC = 16;
  localparam int NB = 16;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_core = '0;
  logic [47:0] req_addr = '0;
  logic [1:0]  req_class = '0;
  logic        req_fetch = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [15:0] resp_mask;
  logic [3:0]  resp_bank;
  logic        resp_viol;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  page_bank_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_core_i(req_core), .req_addr_i(req_addr),
    .req_class_i(req_class), .req_fetch_i(req_fetch),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready),
    .resp_mask_o(resp_mask), .resp_bank_o(resp_bank), .resp_viol_o(resp_viol)
  );

  // core, addr, class, fetch, exp_mask, exp_bank, exp_viol
  localparam logic [3:0]  V_CORE [NV] = '{4'd5, 4'd5, 4'd5, 4'd14, 4'd0, 4'd9, 4'd9, 4'd3, 4'd15, 4'd2};
  localparam logic [47:0] V_ADDR [NV] = '{48'h280, 48'h280, 48'h280, 48'h3C0, 48'h3C0,
                                          48'h140, 48'h140, 48'h0C0, 48'h140, 48'hABCD_0000_017F};
  localparam logic [1:0]  V_CLS  [NV] = '{2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd0, 2'd3, 2'd0, 2'd2};
  localparam logic        V_FET  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [15:0] V_MASK [NV] = '{16'h0020, 16'h00F0, 16'hFFFF, 16'hF000, 16'hFFFF,
                                          16'h0000, 16'h0000, 16'h0000, 16'h8000, 16'hFFFF};
  localparam logic [3:0]  V_BANK [NV] = '{4'd5, 4'd6, 4'd10, 4'd15, 4'd15, 4'd0, 4'd0, 4'd0, 4'd15, 4'd5};
  localparam logic        V_VIOL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  function automatic string req_tag(input logic [1:0] c, input logic f);
    if (c == 2'd3) return "R1";
    if (f != (c == 2'd1)) return "R5";
    if (c == 2'd0) return "R2";
    if (c == 2'd1) return "R3";
    return "R4";
  endfunction

  // independent reference mapping
  task automatic ref_map(input int core, input logic [47:0] addr, input logic [1:0] c,
                         input logic f, output logic [15:0] m, output logic [3:0] b,
                         output logic v);
    int loc, blk;
    loc = core % NB;
    blk = int'(addr / 64);
    m = '0; b = '0;
    v = (c == 2'd3) || (f && c != 2'd1) || (!f && c == 2'd1);
    if (!v) begin
      case (c)
        2'd0: begin b = 4'(loc); m[loc] = 1'b1; end
        2'd1: begin
          b = 4'((loc / 4) * 4 + blk % 4);
          for (int k = 0; k < 4; k++) m[(loc / 4) * 4 + k] = 1'b1;
        end
        default: begin b = 4'(blk % NB); m = '1; end
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [15:0] m, input logic [3:0] b, input logic v);
    n_run++;
    if (resp_valid !== 1'b1 || resp_mask !== m || resp_bank !== b || resp_viol !== v) begin
      n_fail++;
      $display("FAIL %s: got vld=%b mask=%h bank=%0d viol=%b exp vld=1 mask=%h bank=%0d viol=%b",
               tag, resp_valid, resp_mask, resp_bank, resp_viol, m, b, v);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b exp %b", tag, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the negedge where the result is due
  task automatic send(input logic [3:0] c, input logic [47:0] a, input logic [1:0] k, input logic f);
    req_core = c; req_addr = a; req_class = k; req_fetch = f; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] em;
    logic [3:0]  eb;
    logic        ev;
    repeat (3) @(negedge clk);
    // R8 reset state
    check_bit("R8 resp_valid", resp_valid, 1'b0);
    check_bit("R8 mask zero", resp_mask == '0, 1'b1);
    check_bit("R8 req_ready", req_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(V_CORE[i], V_ADDR[i], V_CLS[i], V_FET[i]);
      check({req_tag(V_CLS[i], V_FET[i]), " R6 vector"}, V_MASK[i], V_BANK[i], V_VIOL[i]);
    end

    // full sweep vs reference
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int f = 0; f < 2; f++) begin
          logic [47:0] a;
          a = 48'(c * 37 + k * 11 + f * 5) << 6;
          ref_map(c, a, 2'(k), f[0], em, eb, ev);
          send(4'(c), a, 2'(k), f[0]);
          check({req_tag(2'(k), f[0]), " sweep"}, em, eb, ev);
        end
      end
    end

    // R9 back-to-back
    req_core = 4'd1; req_addr = 48'h1C0; req_class = 2'd2; req_fetch = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R9 b2b first", 16'hFFFF, 4'd7, 1'b0);
    req_core = 4'd6; req_addr = 48'h0C0; req_class = 2'd1; req_fetch = 1'b1;
    @(negedge clk);
    check("R9 b2b second", 16'h00F0, 4'd7, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    check_bit("R9 drain", resp_valid, 1'b0);

    // R7 stall
    resp_ready = 1'b0;
    send(4'd10, 48'h000, 2'd0, 1'b0);
    check("R7 stalled A", 16'h0400, 4'd10, 1'b0);
    req_core = 4'd3; req_addr = 48'h2C0; req_class = 2'd2; req_fetch = 1'b0; req_valid = 1'b1;
    check_bit("R7 ready low", req_ready, 1'b0);
    @(negedge clk);
    check("R7 held 1", 16'h0400, 4'd10, 1'b0);
    @(negedge clk);
    check("R7 held 2", 16'h0400, 4'd10, 1'b0);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 released B", 16'hFFFF, 4'd11, 1'b0);
    @(negedge clk);
    check_bit("R8 idle ready", req_ready, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule